// File: doc/BRIEF.md
# Boxed Dual-Precision Floating-Point Register File

This block holds the floating-point architectural registers of a core that supports single and double precision in one set of 64-bit registers. Each access carries a precision tag. A single-precision write packs its 32-bit value into a 64-bit word whose upper half is all ones. A double-precision write stores the word exactly as given.

There are two combinational read ports. Each port has three outputs. The arithmetic output feeds the execution units. For a single-precision read it checks that the upper half of the register holds a valid box, and if it does not, it substitutes the canonical single-precision NaN. The move output feeds float-to-integer moves. The store output feeds memory stores. Both the move and store outputs pass the raw register bits through with no box check.

Loads and integer-to-float moves reach the block through the same write port, tagged with their precision.

Top module: `fpr_box_file`

## Requirements
- R1: A synchronous active-low reset clears every register to zero; a double read then returns 64'h0 and a single arithmetic read returns the boxed NaN 64'hFFFFFFFF_7FC00000.
- R2: A single-precision write (wr_single=1) stores wr_data[31:0] in bits 31:0 and sets bits 63:32 to all ones, whatever wr_data[63:32] holds.
- R3: A double-precision write (wr_single=0) stores all 64 bits of wr_data unchanged.
- R4: A single-precision arithmetic read of a register whose bits 63:32 are all ones returns the register contents unchanged.
- R5: A single-precision arithmetic read of a register whose bits 63:32 are not all ones returns 64'hFFFFFFFF_7FC00000, which is the canonical NaN 32'h7FC00000 in the low half and ones in the upper half.
- R6: A double-precision arithmetic read returns the full 64-bit register with no box check.
- R7: The move output returns the register's low 32 bits sign-extended from bit 31 to 64 bits when tagged single, and the raw 64 bits when tagged double, never checking the box.
- R8: The store output returns the raw low 32 bits zero-extended to 64 bits when tagged single, and the raw 64 bits when tagged double, never checking the box.
- R9: When a read port addresses the register being written in the same cycle, it returns the old contents until the clock edge, and the new contents after it.
- R10: With wr_en low, no register changes, whatever the other write inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Write register index |
| wr_single | input | 1 | Write precision tag, 1 = single |
| wr_data | input | 64 | Write data |
| ra_addr | input | 5 | Port A register index |
| ra_single | input | 1 | Port A precision tag, 1 = single |
| ra_arith | output | 64 | Port A operand for arithmetic, box checked |
| ra_move | output | 64 | Port A raw data for moves to the integer side |
| ra_store | output | 64 | Port A raw data for memory stores |
| rb_addr | input | 5 | Port B register index |
| rb_single | input | 1 | Port B precision tag, 1 = single |
| rb_arith | output | 64 | Port B operand for arithmetic, box checked |
| rb_move | output | 64 | Port B raw data for moves to the integer side |
| rb_store | output | 64 | Port B raw data for memory stores |

## Verification
A corrupted register shows on the next combinational read of its index, and both the double read and the raw outputs expose every bit of it. A wrong box in the upper half is also seen at once in the single-precision arithmetic output: a broken box turns into the canonical NaN there, while the move and store outputs still show the raw value. A write that lands in the wrong slot, or that changes a register with wr_en low, appears one clock edge later when every register is swept through both ports.

// File: rtl/fpr_box_pkg.sv
// Shared widths and encodings for the boxed floating-point register file.
// Assumes a 64-bit register holding 32-bit single-precision values.
package fpr_box_pkg;
    localparam int FLEN = 64;
    localparam int SLEN = 32;
    localparam int HLEN = FLEN - SLEN;

    localparam logic [SLEN-1:0] SGL_QNAN = 32'h7FC0_0000;
    localparam logic [FLEN-1:0] DBL_QNAN = 64'h7FF8_0000_0000_0000;
    localparam logic [HLEN-1:0] BOX_ONES = '1;

    typedef enum logic {PREC_DBL = 1'b0, PREC_SGL = 1'b1} prec_e;

    // Wrap a single value in the all-ones upper half.
    function automatic logic [FLEN-1:0] box_single(input logic [SLEN-1:0] v);
        return {BOX_ONES, v};
    endfunction

    // True when the upper half of a register word is a valid box.
    function automatic logic box_valid(input logic [FLEN-1:0] w);
        return w[FLEN-1:SLEN] == BOX_ONES;
    endfunction
endpackage

// File: rtl/fpr_wr_format.sv
// Forms the word that is stored by a write.
// Single writes are boxed, and double writes pass through unchanged.
// Purely combinational: the caller registers the result.
module fpr_wr_format
    import fpr_box_pkg::*;
(
    input  logic            single_i,
    input  logic [FLEN-1:0] data_i,
    output logic [FLEN-1:0] word_o
);
    // Select the boxed or raw form of the incoming data.
    always_comb begin
        if (prec_e'(single_i) == PREC_SGL) begin
            word_o = box_single(data_i[SLEN-1:0]);
        end else begin
            word_o = data_i;
        end
    end
endmodule

// File: rtl/fpr_slot_array.sv
// Register storage: NREG words with one write port.
// Each slot decodes its own write enable. Reset is synchronous and active low,
// and it clears every slot to zero. The contents are exposed for the read muxes.
module fpr_slot_array
    import fpr_box_pkg::*;
#(
    parameter int NREG = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we_i,
    input  logic [AW-1:0]   waddr_i,
    input  logic [FLEN-1:0] wword_i,
    output logic [FLEN-1:0] slot_q [NREG]
);
    for (genvar g = 0; g < NREG; g++) begin : g_slot
        logic [FLEN-1:0] word_q;
        logic            hit;

        assign hit = we_i && (waddr_i == AW'(g));

        // Hold one register word, loaded only on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q <= '0;
            end else if (hit) begin
                word_q <= wword_i;
            end
        end

        assign slot_q[g] = word_q;
    end
endmodule

// File: rtl/fpr_read_view.sv
// Derives the three views of one read port from the selected register word.
// arith: box-checked operand, where a broken single box yields the canonical NaN.
// move : raw bits, with the low half sign-extended for singles.
// store: raw bits, with the low half zero-extended for singles.
module fpr_read_view
    import fpr_box_pkg::*;
(
    input  logic            single_i,
    input  logic [FLEN-1:0] word_i,
    output logic [FLEN-1:0] arith_o,
    output logic [FLEN-1:0] move_o,
    output logic [FLEN-1:0] store_o
);
    logic            is_sgl;
    logic [SLEN-1:0] low;

    assign is_sgl = prec_e'(single_i) == PREC_SGL;
    assign low    = word_i[SLEN-1:0];

    // Arithmetic operand: unbox a single, or substitute NaN when the box is broken.
    always_comb begin
        if (!is_sgl) begin
            arith_o = word_i;
        end else if (box_valid(word_i)) begin
            arith_o = word_i;
        end else begin
            arith_o = box_single(SGL_QNAN);
        end
    end

    // Move-to-integer data: raw bits with no box check.
    always_comb begin
        if (is_sgl) begin
            move_o = {{HLEN{low[SLEN-1]}}, low};
        end else begin
            move_o = word_i;
        end
    end

    // Store data: raw bits with no box check.
    always_comb begin
        if (is_sgl) begin
            store_o = {{HLEN{1'b0}}, low};
        end else begin
            store_o = word_i;
        end
    end
endmodule

// File: rtl/fpr_box_file.sv
// Boxed floating-point register file: one write port and two read ports.
// Reads are combinational from the stored words, so a read of the register being
// written in the same cycle sees the old value until the clock edge.
module fpr_box_file
    import fpr_box_pkg::*;
#(
    parameter int NREG = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic            wr_single,
    input  logic [FLEN-1:0] wr_data,
    input  logic [AW-1:0]   ra_addr,
    input  logic            ra_single,
    output logic [FLEN-1:0] ra_arith,
    output logic [FLEN-1:0] ra_move,
    output logic [FLEN-1:0] ra_store,
    input  logic [AW-1:0]   rb_addr,
    input  logic            rb_single,
    output logic [FLEN-1:0] rb_arith,
    output logic [FLEN-1:0] rb_move,
    output logic [FLEN-1:0] rb_store
);
    logic [FLEN-1:0] wword;
    logic [FLEN-1:0] file_q [NREG];
    logic [FLEN-1:0] a_word;
    logic [FLEN-1:0] b_word;

    fpr_wr_format u_wfmt (
        .single_i (wr_single),
        .data_i   (wr_data),
        .word_o   (wword)
    );

    fpr_slot_array #(.NREG(NREG)) u_slots (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (wr_en),
        .waddr_i (wr_addr),
        .wword_i (wword),
        .slot_q  (file_q)
    );

    // Select the addressed words for the two read ports.
    always_comb begin
        a_word = file_q[ra_addr];
        b_word = file_q[rb_addr];
    end

    fpr_read_view u_view_a (
        .single_i (ra_single),
        .word_i   (a_word),
        .arith_o  (ra_arith),
        .move_o   (ra_move),
        .store_o  (ra_store)
    );

    fpr_read_view u_view_b (
        .single_i (rb_single),
        .word_i   (b_word),
        .arith_o  (rb_arith),
        .move_o   (rb_move),
        .store_o  (rb_store)
    );
endmodule

// File: rtl/fpr_box_file_chk.sv
// Property checker for fpr_box_file, attached by bind.
// Observes the write inputs, port A and the stored words.
module fpr_box_file_chk
    import fpr_box_pkg::*;
#(
    parameter int NREG = 32,
    localparam int AW  = $clog2(NREG)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            wr_en,
    input logic [AW-1:0]   wr_addr,
    input logic            wr_single,
    input logic [FLEN-1:0] wr_data,
    input logic [AW-1:0]   ra_addr,
    input logic            ra_single,
    input logic [FLEN-1:0] ra_arith,
    input logic [FLEN-1:0] ra_move,
    input logic [FLEN-1:0] file_q [NREG]
);
    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> file_q[ra_addr] == '0); // R1

    AST_SGL_WRITE_BOXED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_single) |=>
        file_q[$past(wr_addr)] == {32'hFFFF_FFFF, $past(wr_data[SLEN-1:0])}); // R2

    AST_DBL_WRITE_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_single) |=> file_q[$past(wr_addr)] == $past(wr_data)); // R3

    AST_SGL_BOXED_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (ra_single && file_q[ra_addr][FLEN-1:SLEN] == 32'hFFFF_FFFF)
        |-> ra_arith == file_q[ra_addr]); // R4

    AST_SGL_BROKEN_NAN: assert property (@(posedge clk) disable iff (!rst_n)
        (ra_single && file_q[ra_addr][FLEN-1:SLEN] != 32'hFFFF_FFFF)
        |-> ra_arith == 64'hFFFF_FFFF_7FC0_0000); // R5

    AST_DBL_READ_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        !ra_single |-> ra_arith == file_q[ra_addr]); // R6

    AST_MOVE_SIGN_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        ra_single |-> (ra_move[FLEN-1:SLEN] == {HLEN{ra_move[SLEN-1]}}
                       && ra_move[SLEN-1:0] == file_q[ra_addr][SLEN-1:0])); // R7

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && rst_n) |=> file_q[ra_addr] == $past(file_q[ra_addr]) || ra_addr != $past(ra_addr)); // R10
endmodule

bind fpr_box_file fpr_box_file_chk #(.NREG(NREG)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_single (wr_single),
    .wr_data   (wr_data),
    .ra_addr   (ra_addr),
    .ra_single (ra_single),
    .ra_arith  (ra_arith),
    .ra_move   (ra_move),
    .file_q    (file_q)
);

// File: tb/fpr_box_file_test.sv
// Self-checking bench: sweeps every register through both ports under
// single and double writes, broken and valid boxes, idle writes and
// same-cycle read-during-write.
module fpr_box_file_test;
    localparam logic [63:0] BOXED_NAN = 64'hFFFF_FFFF_7FC0_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic        wr_single = 1'b0;
    logic [63:0] wr_data = '0;
    logic [4:0]  ra_addr = '0;
    logic        ra_single = 1'b0;
    logic [4:0]  rb_addr = '0;
    logic        rb_single = 1'b0;
    logic [63:0] ra_arith, ra_move, ra_store, rb_arith, rb_move, rb_store;

    logic [63:0] model [32];
    int          n_vec = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    fpr_box_file uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_single(wr_single), .wr_data(wr_data),
        .ra_addr(ra_addr), .ra_single(ra_single),
        .ra_arith(ra_arith), .ra_move(ra_move), .ra_store(ra_store),
        .rb_addr(rb_addr), .rb_single(rb_single),
        .rb_arith(rb_arith), .rb_move(rb_move), .rb_store(rb_store)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Write at a negedge; the register updates at the following posedge.
    task automatic do_write(input logic [4:0] a, input logic sgl, input logic [63:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_single = sgl; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        model[a] = sgl ? {32'hFFFF_FFFF, d[31:0]} : d;
    endtask

    task automatic set_ports(input logic [4:0] a, input logic sa, input logic [4:0] b, input logic sb);
        ra_addr = a; ra_single = sa; rb_addr = b; rb_single = sb;
        #1;
    endtask

    function automatic logic [63:0] arith_exp(input logic [63:0] w);
        return (w[63:32] == 32'hFFFF_FFFF) ? w : BOXED_NAN;
    endfunction

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 / R5: cleared registers, zero upper half is a broken box
        for (int i = 0; i < 32; i++) begin
            set_ports(5'(i), 1'b0, 5'(31 - i), 1'b1);
            chk("R1 reset double read", ra_arith, 64'h0);
            chk("R1 R5 reset single read", rb_arith, BOXED_NAN);
        end

        // R2 / R4 / R7 / R8: single writes with junk upper input bits
        for (int i = 0; i < 32; i++) begin
            logic [31:0] v;
            v = (i[0] ? 32'h8000_0000 : 32'h0) | (32'(i) * 32'h0001_2345);
            do_write(5'(i), 1'b1, {32'h1234_5678 ^ 32'(i), v});
        end
        for (int i = 0; i < 32; i++) begin
            set_ports(5'(i), 1'b0, 5'(i), 1'b1);
            chk("R2 single write boxed", ra_arith, model[i]);
            chk("R4 boxed single read", rb_arith, model[i]);
            chk("R8 single store zext", rb_store, {32'h0, model[i][31:0]});
            ra_single = 1'b1; #1;
            chk("R7 single move sext", ra_move, {{32{model[i][31]}}, model[i][31:0]});
        end

        // R3 / R5 / R6 / R7 / R8: double writes on even regs, broken boxes
        for (int i = 0; i < 32; i += 2) begin
            logic [63:0] d;
            d = {(32'(i) * 32'h0101_0101) ^ 32'h5A5A_5A5A, 32'hF000_0001 + 32'(i)};
            if (i == 2) d = 64'hFFFF_FFFF_3F80_0000;
            do_write(5'(i), 1'b0, d);
        end
        for (int i = 0; i < 32; i++) begin
            set_ports(5'(i), 1'b0, 5'(i), 1'b1);
            chk("R3 R6 double read", ra_arith, model[i]);
            chk("R4 R5 single arith", rb_arith, arith_exp(model[i]));
            chk("R7 raw single move", rb_move, {{32{model[i][31]}}, model[i][31:0]});
            chk("R8 raw single store", rb_store, {32'h0, model[i][31:0]});
            chk("R7 double move raw", ra_move, model[i]);
            chk("R8 double store raw", ra_store, model[i]);
        end
        do_write(5'd9, 1'b0, 64'h7FF8_0000_0000_0000);
        set_ports(5'd9, 1'b0, 5'd9, 1'b1);
        chk("R6 double NaN full", ra_arith, 64'h7FF8_0000_0000_0000);
        chk("R5 single over double", rb_arith, BOXED_NAN);

        // R10: idle write inputs change nothing
        @(negedge clk);
        wr_en = 1'b0; wr_addr = 5'd5; wr_single = 1'b0; wr_data = 64'hDEAD_BEEF_CAFE_F00D;
        repeat (2) @(negedge clk);
        for (int i = 0; i < 32; i++) begin
            set_ports(5'(i), 1'b0, 5'(i), 1'b0);
            chk("R10 idle no change", ra_arith, model[i]);
        end

        // R9: same-cycle read sees old value until the edge
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 5'd7; wr_single = 1'b0; wr_data = 64'h0123_4567_89AB_CDEF;
        set_ports(5'd7, 1'b0, 5'd7, 1'b1);
        chk("R9 old value before edge", ra_arith, model[7]);
        chk("R9 old value port B", rb_arith, arith_exp(model[7]));
        @(negedge clk);
        wr_en = 1'b0;
        model[7] = 64'h0123_4567_89AB_CDEF;
        #1;
        chk("R9 new value after edge", ra_arith, model[7]);
        chk("R9 new value port B", rb_arith, BOXED_NAN);

        // R1: reset again after activity
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 32; i++) begin
            set_ports(5'(i), 1'b0, 5'(i), 1'b0);
            chk("R1 re-reset", rb_arith, 64'h0);
        end

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule